// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is the slave-side front end of a two-wire serial bus that steers a digitally adjustable potentiometer. It oversamples the bus clock and data lines with the system clock and finds start and stop conditions. It checks the first byte against a fixed device-type code plus three strap pins. It then decodes a command byte and turns each complete transaction into single-cycle strobes for a wiper register and a small bank of saved settings that sit next to it.

Two-byte commands move a value between the wiper and one saved register. Three-byte commands write a 6-bit value that the master supplies, or return a 6-bit value to the master. A stepping command turns every later bus clock pulse into a one-position wiper move, with the direction chosen by the data level, until the master ends the transaction. The block drives only an open-drain pull-down enable for the data line. This enable carries the acknowledge bits and the read data.

Top module: `potbus_slave`

## Requirements
- R1: After reset the data pull-down is released, every strobe is low, and `reg_sel` and `wr_data` are zero.
- R2: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high. A stop releases the data line and ends the transaction. A start at any point drops the transaction under way, with no strobe for it, and begins a new address phase.
- R3: The first byte, sent MSB first, is acknowledged only if it equals {0,1,0,1, pin_addr[2], pin_addr[1], 0, pin_addr[0]}. Any other byte gets no acknowledge, and the block stays silent until the next start.
- R4: While `busy` is high at the end of the address byte, the address is not acknowledged.
- R5: The command byte carries the opcode in bits 7:4 and the register select in bits 3:2. The opcodes are 1001 read wiper, 1010 write wiper, 1011 read saved register, 1100 write saved register, 1101 load wiper from saved register, 1110 store wiper to saved register, and 0010 stepping. Any other opcode is not acknowledged.
- R6: An acknowledge pulls the data line low from the clock fall after the eighth bit until the clock fall after the ninth bit, and then releases it.
- R7: Write wiper (1010) takes a third byte. Its bits 5:0 appear on `wr_data` with a one-cycle `wiper_wr`, and its bits 7:6 are ignored. The byte is acknowledged.
- R8: Write saved register (1100) gives a one-cycle `bank_wr`, with the third byte's bits 5:0 on `wr_data` and the command's bits 3:2 on `reg_sel`.
- R9: The read opcodes pulse `wiper_rd` (1001) or `bank_rd` (1011, with `reg_sel`) when the command byte is accepted. The slave then sends 0,0 followed by `rd_data[5:0]` MSB first, with `rd_data` sampled at the clock fall that ends the command acknowledge. It releases the line for the master's acknowledge.
- R10: Opcode 1101 pulses `load_wiper` and opcode 1110 pulses `store_wiper`, each with `reg_sel`, when the command byte is accepted. No further byte follows.
- R11: After the stepping command is acknowledged, each complete clock high pulse gives one `step_up` if the data line was high at its rising edge, or one `step_dn` if it was low. The strobe comes after the clock falls.
- R12: A clock high pulse that ends in a stop or a start gives no step.
- R13: The data pull-down changes only while the clock line is low, except for its release on a start or stop.
- R14: At most one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_addr | input | 3 | Strap bits compared with address bits 3, 2 and 0 |
| busy | input | 1 | Saved-register store in progress; refuse the address |
| rd_data | input | 6 | Value returned by a read command |
| reg_sel | output | 2 | Saved-register select from the command byte |
| wr_data | output | 6 | Value for the write strobes |
| wiper_wr | output | 1 | Write `wr_data` to the wiper |
| bank_wr | output | 1 | Write `wr_data` to saved register `reg_sel` |
| wiper_rd | output | 1 | Read request for the wiper |
| bank_rd | output | 1 | Read request for saved register `reg_sel` |
| load_wiper | output | 1 | Copy saved register `reg_sel` into the wiper |
| store_wiper | output | 1 | Copy the wiper into saved register `reg_sel` |
| step_up | output | 1 | Move the wiper one position up |
| step_dn | output | 1 | Move the wiper one position down |

## Verification
The assertions check on every cycle that the strobes are exclusive and last one cycle. They also check that the pull-down moves only in clock-low time or on a start or stop, and that start and stop release the line. They further check that write strobes follow a clock rise, that step strobes follow a clock fall, and that a stop is never followed by a step. Address matching, busy refusal, opcode rejection, read data order, aborted writes and the count and direction of steps all depend on whole bus sequences. Only the bench scenarios show these, by comparing every strobe with a queue of expected events from its own register model.

// File: rtl/potbus_pkg.sv
package potbus_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] TYPE_CODE = 4'b0101;

  typedef enum logic [3:0] {
    OP_STEP     = 4'b0010,
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_BANK  = 4'b1011,
    OP_WR_BANK  = 4'b1100,
    OP_LOAD     = 4'b1101,
    OP_STORE    = 4'b1110
  } opcode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_WDATA, S_RDATA, S_STEP, S_HOLD
  } state_e;

  // Decoded command: to_bank selects the saved register (write/read)
  // or the wiper-to-register direction (transfer).
  typedef struct packed {
    logic valid;
    logic is_write;
    logic is_read;
    logic is_xfer;
    logic is_step;
    logic to_bank;
  } cmd_t;

  function automatic logic [BYTE_W-1:0] addr_byte(input logic [2:0] pins);
    return {TYPE_CODE, pins[2], pins[1], 1'b0, pins[0]};
  endfunction
endpackage

// File: rtl/potbus_linesync.sv
module potbus_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  // Idle bus is high: reset to ones so no false edge appears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/potbus_decode.sv
module potbus_decode #(
  parameter int SEL_W = 2
) (
  input  logic [5:0]       cmd_hi,
  output potbus_pkg::cmd_t cmd,
  output logic [SEL_W-1:0] sel
);
  import potbus_pkg::*;

  always_comb begin
    cmd = '0;
    sel = cmd_hi[SEL_W-1:0];
    case (cmd_hi[5:2])
      OP_WR_WIPER: begin cmd.valid = 1'b1; cmd.is_write = 1'b1; end
      OP_WR_BANK:  begin cmd.valid = 1'b1; cmd.is_write = 1'b1; cmd.to_bank = 1'b1; end
      OP_RD_WIPER: begin cmd.valid = 1'b1; cmd.is_read = 1'b1; end
      OP_RD_BANK:  begin cmd.valid = 1'b1; cmd.is_read = 1'b1; cmd.to_bank = 1'b1; end
      OP_LOAD:     begin cmd.valid = 1'b1; cmd.is_xfer = 1'b1; end
      OP_STORE:    begin cmd.valid = 1'b1; cmd.is_xfer = 1'b1; cmd.to_bank = 1'b1; end
      OP_STEP:     begin cmd.valid = 1'b1; cmd.is_step = 1'b1; end
      default:     cmd = '0;
    endcase
  end
endmodule

// File: rtl/potbus_slave.sv
module potbus_slave #(
  parameter int DATA_W      = 6,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        pin_addr,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              wiper_wr,
  output logic              bank_wr,
  output logic              wiper_rd,
  output logic              bank_rd,
  output logic              load_wiper,
  output logic              store_wiper,
  output logic              step_up,
  output logic              step_dn
);
  import potbus_pkg::*;

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam int PAD_W = BYTE_W - DATA_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  // Bus events, brought out as named wires for the checker.
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  potbus_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  state_e            state, pend;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic              wr_to_bank, step_armed, step_dir;

  logic [BYTE_W-1:0] rx_byte;
  logic              last_rise, addr_hit, in_step;
  logic [BYTE_W-1:0] rd_frame;
  cmd_t              cmd;
  logic [SEL_W-1:0]  cmd_sel;

  assign rx_byte   = {shreg[BYTE_W-2:0], sda_s};
  assign last_rise = scl_rise && (bitcnt == LAST_BIT);
  assign addr_hit  = (rx_byte == addr_byte(pin_addr)) && !busy;
  assign rd_frame  = {{PAD_W{1'b0}}, rd_data};
  assign in_step   = (state == S_STEP);

  potbus_decode #(.SEL_W(SEL_W)) u_dec (
    .cmd_hi(rx_byte[BYTE_W-1:2]), .cmd(cmd), .sel(cmd_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;      pend <= S_IDLE;
      bitcnt <= '0;         shreg <= '0;       tx <= '0;
      sda_oe <= 1'b0;       wr_to_bank <= 1'b0;
      step_armed <= 1'b0;   step_dir <= 1'b0;
      reg_sel <= '0;        wr_data <= '0;
      wiper_wr <= 1'b0;     bank_wr <= 1'b0;
      wiper_rd <= 1'b0;     bank_rd <= 1'b0;
      load_wiper <= 1'b0;   store_wiper <= 1'b0;
      step_up <= 1'b0;      step_dn <= 1'b0;
    end else begin
      wiper_wr <= 1'b0;     bank_wr <= 1'b0;
      wiper_rd <= 1'b0;     bank_rd <= 1'b0;
      load_wiper <= 1'b0;   store_wiper <= 1'b0;
      step_up <= 1'b0;      step_dn <= 1'b0;
      if (start_evt) begin
        state <= S_ADDR;  bitcnt <= '0;  sda_oe <= 1'b0;  step_armed <= 1'b0;
      end else if (stop_evt) begin
        state <= S_IDLE;  bitcnt <= '0;  sda_oe <= 1'b0;  step_armed <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_CMD, S_WDATA: begin
            if (scl_rise) begin
              if (bitcnt < ACK_SLOT) begin
                shreg  <= rx_byte;
                bitcnt <= bitcnt + 1'b1;
              end else begin
                bitcnt <= ACK_DONE;
              end
              if (last_rise) begin
                if (state == S_ADDR) begin
                  if (addr_hit) pend <= S_CMD;
                  else          state <= S_IDLE;
                end else if (state == S_CMD) begin
                  if (cmd.valid) begin
                    reg_sel    <= cmd_sel;
                    wr_to_bank <= cmd.to_bank;
                    if (cmd.is_write) begin
                      pend <= S_WDATA;
                    end else if (cmd.is_read) begin
                      pend     <= S_RDATA;
                      wiper_rd <= !cmd.to_bank;
                      bank_rd  <= cmd.to_bank;
                    end else if (cmd.is_xfer) begin
                      pend        <= S_HOLD;
                      load_wiper  <= !cmd.to_bank;
                      store_wiper <= cmd.to_bank;
                    end else begin
                      pend <= S_STEP;
                    end
                  end else begin
                    state <= S_IDLE;
                  end
                end else begin
                  pend     <= S_HOLD;
                  wr_data  <= rx_byte[DATA_W-1:0];
                  wiper_wr <= !wr_to_bank;
                  bank_wr  <= wr_to_bank;
                end
              end
            end else if (scl_fall) begin
              if (bitcnt == ACK_SLOT) begin
                sda_oe <= 1'b1;
              end else if (bitcnt == ACK_DONE) begin
                bitcnt <= '0;
                state  <= pend;
                if (pend == S_RDATA) begin
                  tx     <= rd_frame;
                  sda_oe <= ~rd_frame[BYTE_W-1];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          S_RDATA: begin
            if (scl_rise) begin
              if (bitcnt < ACK_DONE) bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt < ACK_SLOT) begin
                tx     <= tx << 1;
                sda_oe <= ~tx[BYTE_W-2];
              end else if (bitcnt == ACK_SLOT) begin
                sda_oe <= 1'b0;
              end else begin
                state  <= S_HOLD;
                bitcnt <= '0;
              end
            end
          end
          S_STEP: begin
            if (scl_rise) begin
              step_armed <= 1'b1;
              step_dir   <= sda_s;
            end else if (scl_fall && step_armed) begin
              step_armed <= 1'b0;
              step_up    <= step_dir;
              step_dn    <= !step_dir;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/potbus_checks.sv
module potbus_checks (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_rise,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic in_step,
  input logic sda_oe,
  input logic wiper_wr,
  input logic bank_wr,
  input logic wiper_rd,
  input logic bank_rd,
  input logic load_wiper,
  input logic store_wiper,
  input logic step_up,
  input logic step_dn
);
  logic [7:0] strobes;
  assign strobes = {wiper_wr, bank_wr, wiper_rd, bank_rd,
                    load_wiper, store_wiper, step_up, step_dn};

  p_one_strobe_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  p_short_strobe_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes != 8'd0) |=> ((strobes & $past(strobes)) == 8'd0));

  p_oe_moves_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_evt) || $past(stop_evt)));

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  p_write_after_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_wr || bank_wr) |-> $past(scl_rise));

  p_step_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> ($past(scl_fall) && $past(in_step)));

  p_no_step_on_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !(step_up || step_dn));
endmodule

bind potbus_slave potbus_checks u_checks (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
  .in_step(in_step), .sda_oe(sda_oe), .wiper_wr(wiper_wr),
  .bank_wr(bank_wr), .wiper_rd(wiper_rd), .bank_rd(bank_rd),
  .load_wiper(load_wiper), .store_wiper(store_wiper),
  .step_up(step_up), .step_dn(step_dn)
);

// File: tb/test_potbus_slave.sv
module test_potbus_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] pins = 3'b101;
  logic [5:0] rd_data = 6'd0;
  logic       sda_oe, wiper_wr, bank_wr, wiper_rd, bank_rd;
  logic       load_wiper, store_wiper, step_up, step_dn;
  logic [1:0] reg_sel;
  logic [5:0] wr_data;
  wire        sda_line = m_sda & ~sda_oe;

  potbus_slave i_potbus_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .pin_addr(pins), .busy(busy), .rd_data(rd_data), .reg_sel(reg_sel),
    .wr_data(wr_data), .wiper_wr(wiper_wr), .bank_wr(bank_wr),
    .wiper_rd(wiper_rd), .bank_rd(bank_rd), .load_wiper(load_wiper),
    .store_wiper(store_wiper), .step_up(step_up), .step_dn(step_dn)
  );

  int errors = 0, checks = 0, cyc = 0;
  int expq[$];
  int m_wiper = 0;
  int m_bank[4] = '{0, 0, 0, 0};
  int kind, obs, e, es, ed;
  string tag;

  function automatic int ev(int k, int s, int d);
    return k * 1000 + s * 100 + d;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: every strobe is compared with the next expected event,
  // and the bench's own register model follows the expected values.
  always @(negedge clk) begin
    if (rst_n) begin
      kind = 0;
      if (wiper_wr) kind = 1;
      else if (bank_wr) kind = 2;
      else if (wiper_rd) kind = 3;
      else if (bank_rd) kind = 4;
      else if (load_wiper) kind = 5;
      else if (store_wiper) kind = 6;
      else if (step_up) kind = 7;
      else if (step_dn) kind = 8;
      if (kind != 0) begin
        obs = ev(kind, (kind inside {2, 4, 5, 6}) ? int'(reg_sel) : 0,
                 (kind <= 2) ? int'(wr_data) : 0);
        case (kind)
          1: tag = "R7 wiper write";
          2: tag = "R8 saved write";
          3, 4: tag = "R9 read request";
          5, 6: tag = "R10 transfer";
          default: tag = "R11 step";
        endcase
        if (expq.size() == 0) begin
          check(1'b0, "R14 unexpected strobe", obs, -1);
        end else begin
          e = expq.pop_front();
          check(obs == e, tag, obs, e);
          es = (e / 100) % 10;
          ed = e % 100;
          case (e / 1000)
            1: m_wiper = ed;
            2: m_bank[es] = ed;
            3: rd_data = 6'(m_wiper);
            4: rd_data = 6'(m_bank[es]);
            5: m_wiper = m_bank[es];
            6: m_bank[es] = m_wiper;
            7: m_wiper = (m_wiper < 63) ? m_wiper + 1 : 63;
            default: m_wiper = (m_wiper > 0) ? m_wiper - 1 : 0;
          endcase
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(2 * Q);
  endtask

  task automatic clk_bit(bit b, output bit seen);
    m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); seen = sda_line; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(1'b1, s);
  endtask

  task automatic drained(string req);
    wt(4 * Q);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic open_cmd(logic [7:0] a, logic [7:0] c, string req);
    bit ak;
    bus_start();
    send_byte(a, ak);
    check(ak, "R3 address ack", ak, 1);
    send_byte(c, ak);
    check(ak, req, ak, 1);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] c, logic [7:0] d, string req);
    bit ak;
    open_cmd(a, c, req);
    send_byte(d, ak);
    check(ak, req, ak, 1);
    check(sda_oe == 1'b0, "R6 release after ack", sda_oe, 0);
    bus_stop();
    drained(req);
  endtask

  task automatic do_read(logic [7:0] a, logic [7:0] c, string req);
    logic [7:0] got;
    open_cmd(a, c, req);
    recv_byte(got);
    bus_stop();
    check(got == 8'(m_wiper) || c[7:4] == 4'b1011, req, got, m_wiper);
    if (c[7:4] == 4'b1011)
      check(got == 8'(m_bank[c[3:2]]), req, got, m_bank[c[3:2]]);
    drained(req);
  endtask

  task automatic do_two(logic [7:0] a, logic [7:0] c, string req);
    open_cmd(a, c, req);
    bus_stop();
    drained(req);
  endtask

  task automatic expect_silent_addr(logic [7:0] a, string req);
    bit ak;
    bus_start();
    send_byte(a, ak);
    check(!ak, req, ak, 0);
    bus_stop();
    drained(req);
  endtask

  task automatic expect_bad_cmd(logic [7:0] a, logic [7:0] c);
    bit ak;
    bus_start();
    send_byte(a, ak);
    check(ak, "R3 address ack", ak, 1);
    send_byte(c, ak);
    check(!ak, "R5 unknown opcode refused", ak, 0);
    bus_stop();
    drained("R5 no strobe for unknown opcode");
  endtask

  initial begin
    bit s, ak;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1 pull-down released", sda_oe, 0);
    check({wiper_wr, bank_wr, wiper_rd, bank_rd, load_wiper, store_wiper,
           step_up, step_dn} == 8'd0, "R1 strobes low", 0, 0);
    check(reg_sel == 2'd0 && wr_data == 6'd0, "R1 outputs zero", wr_data, 0);

    // R7: bits 7:6 of the data byte ignored
    expq.push_back(ev(1, 0, 5));
    do_write(8'h59, 8'hA0, 8'hC5, "R7 write wiper");
    // R8
    expq.push_back(ev(2, 2, 42));
    do_write(8'h59, 8'hC8, 8'h2A, "R8 write saved register");
    // R9
    expq.push_back(ev(4, 2, 0));
    do_read(8'h59, 8'hB8, "R9 read saved register");
    expq.push_back(ev(3, 0, 0));
    do_read(8'h59, 8'h90, "R9 read wiper");
    // R10
    expq.push_back(ev(5, 2, 0));
    do_two(8'h59, 8'hD8, "R10 load wiper");
    expq.push_back(ev(6, 3, 0));
    do_two(8'h59, 8'hEC, "R10 store wiper");
    expq.push_back(ev(4, 3, 0));
    do_read(8'h59, 8'hBC, "R9 read after store");

    // R11 stepping, R12 stop pulse gives no step
    expq.push_back(ev(7, 0, 0)); expq.push_back(ev(7, 0, 0));
    expq.push_back(ev(7, 0, 0)); expq.push_back(ev(8, 0, 0));
    open_cmd(8'h59, 8'h20, "R11 stepping command");
    clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    bus_stop();
    drained("R12 no step from stop pulse");
    expq.push_back(ev(3, 0, 0));
    do_read(8'h59, 8'h90, "R11 wiper after steps");

    // R2 start aborts a write mid-byte
    open_cmd(8'h59, 8'hA0, "R5 write wiper command");
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    expq.push_back(ev(3, 0, 0));
    open_cmd(8'h59, 8'h90, "R2 restart after abort");
    begin
      logic [7:0] got;
      recv_byte(got);
      bus_stop();
      check(got == 8'(m_wiper), "R2 aborted write left no trace", got, m_wiper);
    end
    drained("R2 abort");

    // R12 start ends stepping without a step
    expq.push_back(ev(7, 0, 0));
    open_cmd(8'h59, 8'h20, "R11 stepping command");
    clk_bit(1'b1, s);
    expq.push_back(ev(3, 0, 0));
    open_cmd(8'h59, 8'h90, "R12 restart from stepping");
    begin
      logic [7:0] got;
      recv_byte(got);
      bus_stop();
      check(got == 8'(m_wiper), "R12 one step only", got, m_wiper);
    end
    drained("R12 restart");

    // R3 address mismatches
    expect_silent_addr(8'h58, "R3 strap bit mismatch");
    expect_silent_addr(8'h5B, "R3 fixed zero bit set");
    expect_silent_addr(8'hD9, "R3 wrong type code");

    // R4 busy refuses the address
    busy = 1'b1;
    expect_silent_addr(8'h59, "R4 busy refuses address");
    busy = 1'b0;
    bus_start();
    send_byte(8'h59, ak);
    check(ak, "R4 address acked when idle", ak, 1);
    bus_stop();

    // R5 unknown opcodes
    expect_bad_cmd(8'h59, 8'hF0);
    expect_bad_cmd(8'h59, 8'h00);
    expect_bad_cmd(8'h59, 8'h80);

    // R3 new strap pins
    pins = 3'b010;
    expect_silent_addr(8'h59, "R3 old address refused");
    expq.push_back(ev(2, 1, 63));
    do_write(8'h54, 8'hC4, 8'h3F, "R8 write with new address");

    wt(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule